// File: doc/BRIEF.md
# Serial Receive Engine with Line-Error Detection

This block turns an asynchronous serial line into characters. An oversampling tick from a shared baud generator paces it. On each tick it looks at the line. A high-to-low transition starts a character. The start bit is confirmed half a bit later. Data bits are then captured at the middle of each bit period, least significant bit first. The character length is programmable from 5 to 8 bits. An optional parity bit follows the data, and one stop bit ends the character.

Each finished character goes to an external receive FIFO. It is presented on a data bus with a one-cycle push strobe, and it is pushed even when it is bad. Three line-error conditions are kept as sticky flags: parity error, framing error, and break (the line held low for a whole character time). Software clears each flag by pulsing its clear input, and a combined line-status output is high while any flag is set. A receive-reset input puts the engine back to idle without touching the flags.

The line input is assumed to be already synchronised to `clk`, and the configuration inputs are assumed to be held steady while a character is being received.

Top module: `uart_rx_engine`

## Requirements
- R1: After reset (`rst_n` low at a clock edge) `push`, `push_data`, all three flags and `line_status` are 0.
- R2: Data bits are assembled LSB first. `cfg_wlen` selects the length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. The character appears right-aligned on `push_data` with the unused upper bits at 0.
- R3: The oversample factor M is 16 when `cfg_alt_os` is 0, and `cfg_ext_div`+1 when it is 1. In that mode `cfg_ext_div` must be at least 8. A bit lasts M ticks, and each bit is sampled M/2 ticks after its first tick.
- R4: A start is a low tick that follows a high tick. If the line is high at the start bit's mid-bit sample, reception is abandoned with no push.
- R5: With `cfg_par_en`=1 and `cfg_stick`=0, a parity bit is checked between the last data bit and the stop bit. `cfg_even`=1 requires an even count of ones over data plus parity, and `cfg_even`=0 requires an odd count. A mismatch sets `flag_pe`.
- R6: With `cfg_par_en`=1 and `cfg_stick`=1, the expected parity bit is the constant NOT `cfg_even`. A mismatch sets `flag_pe`.
- R7: A stop-bit sample of 0 sets `flag_fe`. A character with a parity or framing error is still pushed.
- R8: `flag_bi` sets once the line has been low for M×(1+data bits+parity bits+1) ticks without a break. A shorter low period, such as an all-zero character with a valid stop bit, leaves it clear.
- R9: Each flag stays set until its clear strobe (`clr_pe`, `clr_fe`, `clr_bi`) is high at a clock edge. If a set and a clear of the same flag fall in the same cycle, the set wins.
- R10: `line_status` is the OR of the three flags and falls only when a clear brings the last set flag low.
- R11: `rx_rst` discards any partial character and returns the engine to idle. No push follows it, and the flags are unchanged.
- R12: `push` is high for exactly one clock for each accepted character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_rst | input | 1 | Receive-engine reset, synchronous, active high |
| os_tick | input | 1 | Oversampling tick, one clock wide |
| rx_in | input | 1 | Serial line, already synchronised |
| cfg_wlen | input | 2 | Word length code |
| cfg_par_en | input | 1 | Parity enable |
| cfg_even | input | 1 | Even parity select (picks the constant in stick mode) |
| cfg_stick | input | 1 | Stick parity enable |
| cfg_alt_os | input | 1 | Use the extra divider for the oversample factor |
| cfg_ext_div | input | DIV_W | Extra divider; M = value+1 |
| clr_pe | input | 1 | Clear strobe for the parity error flag |
| clr_fe | input | 1 | Clear strobe for the framing error flag |
| clr_bi | input | 1 | Clear strobe for the break flag |
| push | output | 1 | Push strobe to the receive FIFO |
| push_data | output | DATA_W | Received character, right-aligned |
| flag_pe | output | 1 | Sticky parity error |
| flag_fe | output | 1 | Sticky framing error |
| flag_bi | output | 1 | Sticky break |
| line_status | output | 1 | OR of the three flags |

## Verification
A hardware set of an error flag and a software clear of the same flag can land in the same clock. The bench watches for the push strobe of a character sent with a bad stop bit. It raises `clr_fe` for exactly the next clock, which is the clock in which the framing flag is being set. The flag must read 1 afterwards, and a later clear on its own must bring it and `line_status` to 0. The break counter and the character framer also both act on one long low period. The bench checks that this gives one zero character with a framing error and a break flag, and no second start.

// File: rtl/uart_rx_pkg.sv
// Shared types and helpers for the serial receive engine.
package uart_rx_pkg;

    // Receive framer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_t;

    // Number of data bits for a word-length code (5..8).
    function automatic logic [3:0] word_bits(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

endpackage

// File: rtl/uart_rx_frame.sv
// Character framer. It validates the start bit at mid-bit, shifts in
// the data LSB first, checks parity and the stop bit, and produces a
// one-cycle push with the right-aligned character.
// It assumes rx_in is synchronous and the configuration is steady
// during a character.
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int MW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_rst,
    input  logic              os_tick,
    input  logic              rx_in,
    input  logic [MW-1:0]     os_m,
    input  logic [1:0]        cfg_wlen,
    input  logic              cfg_par_en,
    input  logic              cfg_even,
    input  logic              cfg_stick,
    output logic              push,
    output logic [DATA_W-1:0] push_data,
    output logic              pe_set,
    output logic              fe_set
);
    localparam int BCW = $clog2(DATA_W);

    rx_state_t         state;
    logic [MW-1:0]     cnt;
    logic [BCW-1:0]    bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              par_acc;
    logic              par_err;
    logic              rx_prev;

    logic [3:0]        nbits;
    logic [MW-1:0]     half_m1;
    logic [MW-1:0]     last_m1;
    logic              bit_end;
    logic              exp_par;

    // Decode per-character constants from the configuration.
    always_comb begin
        nbits   = word_bits(cfg_wlen);
        half_m1 = (os_m >> 1) - MW'(1);
        last_m1 = os_m - MW'(1);
        bit_end = (cnt == last_m1);
        exp_par = cfg_stick ? ~cfg_even : (cfg_even ? par_acc : ~par_acc);
    end

    // Framer state machine, sampling on oversample ticks only.
    always_ff @(posedge clk) begin
        if (!rst_n || rx_rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            par_acc   <= 1'b0;
            par_err   <= 1'b0;
            rx_prev   <= 1'b1;
            push      <= 1'b0;
            push_data <= '0;
            pe_set    <= 1'b0;
            fe_set    <= 1'b0;
        end else begin
            push   <= 1'b0;
            pe_set <= 1'b0;
            fe_set <= 1'b0;
            if (os_tick) begin
                rx_prev <= rx_in;
                unique case (state)
                    ST_IDLE: begin
                        if (!rx_in && rx_prev) begin
                            state <= ST_START;
                            cnt   <= '0;
                        end
                    end
                    ST_START: begin
                        if (cnt == half_m1) begin
                            state   <= rx_in ? ST_IDLE : ST_DATA;
                            cnt     <= '0;
                            bit_idx <= '0;
                            par_acc <= 1'b0;
                            par_err <= 1'b0;
                        end else begin
                            cnt <= cnt + MW'(1);
                        end
                    end
                    ST_DATA: begin
                        if (bit_end) begin
                            cnt     <= '0;
                            shreg   <= {rx_in, shreg[DATA_W-1:1]};
                            par_acc <= par_acc ^ rx_in;
                            if (bit_idx == BCW'(nbits - 4'd1))
                                state <= cfg_par_en ? ST_PAR : ST_STOP;
                            else
                                bit_idx <= bit_idx + BCW'(1);
                        end else begin
                            cnt <= cnt + MW'(1);
                        end
                    end
                    ST_PAR: begin
                        if (bit_end) begin
                            cnt     <= '0;
                            par_err <= (rx_in != exp_par);
                            state   <= ST_STOP;
                        end else begin
                            cnt <= cnt + MW'(1);
                        end
                    end
                    ST_STOP: begin
                        if (bit_end) begin
                            cnt       <= '0;
                            push      <= 1'b1;
                            push_data <= shreg >> (DATA_W - int'(nbits));
                            pe_set    <= cfg_par_en & par_err;
                            fe_set    <= ~rx_in;
                            state     <= ST_IDLE;
                        end else begin
                            cnt <= cnt + MW'(1);
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/uart_rx_break.sv
// Break detector. It counts oversample ticks while the line is low and
// pulses bi_set once when the count reaches one character time. Any
// high level restarts the count.
module uart_rx_break #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_rst,
    input  logic          os_tick,
    input  logic          rx_in,
    input  logic [CW-1:0] char_ticks,
    output logic          bi_set
);
    logic [CW-1:0] low_cnt;

    // Low-time counter that saturates at one character time.
    always_ff @(posedge clk) begin
        if (!rst_n || rx_rst) begin
            low_cnt <= '0;
            bi_set  <= 1'b0;
        end else begin
            bi_set <= 1'b0;
            if (rx_in) begin
                low_cnt <= '0;
            end else if (os_tick && low_cnt != char_ticks) begin
                low_cnt <= low_cnt + CW'(1);
                if (low_cnt + CW'(1) == char_ticks)
                    bi_set <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/uart_rx_flags.sv
// Sticky error flags with write-1-to-clear strobes. If a set and a
// clear of the same flag arrive together, the set wins.
module uart_rx_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        // One sticky bit.
        always_ff @(posedge clk) begin
            if (!rst_n) flag_o[g] <= 1'b0;
            else        flag_o[g] <= (flag_o[g] & ~clr_i[g]) | set_i[g];
        end
    end

endmodule

// File: rtl/uart_rx_engine.sv
// Serial receive engine top. It derives the oversample factor and the
// character time from the configuration, and joins the framer, the
// break detector and the sticky flags.
// It assumes that in alternate mode cfg_ext_div is at least 8.
module uart_rx_engine #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 4,
    parameter int DEF_OS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_rst,
    input  logic             os_tick,
    input  logic             rx_in,
    input  logic [1:0]       cfg_wlen,
    input  logic             cfg_par_en,
    input  logic             cfg_even,
    input  logic             cfg_stick,
    input  logic             cfg_alt_os,
    input  logic [DIV_W-1:0] cfg_ext_div,
    input  logic             clr_pe,
    input  logic             clr_fe,
    input  logic             clr_bi,
    output logic             push,
    output logic [DATA_W-1:0] push_data,
    output logic             flag_pe,
    output logic             flag_fe,
    output logic             flag_bi,
    output logic             line_status
);
    localparam int MW     = DIV_W + 1;
    localparam int CHAR_W = MW + 4;

    logic [MW-1:0]     os_m;
    logic [CHAR_W-1:0] char_ticks;
    logic              pe_set, fe_set, bi_set;
    logic [2:0]        flags;

    // Oversample factor and whole-character length in ticks.
    always_comb begin
        os_m       = cfg_alt_os ? (MW'(cfg_ext_div) + MW'(1)) : MW'(DEF_OS);
        char_ticks = CHAR_W'(os_m) *
                     (CHAR_W'(uart_rx_pkg::word_bits(cfg_wlen)) +
                      CHAR_W'(2) + CHAR_W'(cfg_par_en));
    end

    uart_rx_frame #(.DATA_W(DATA_W), .MW(MW)) i_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_rst     (rx_rst),
        .os_tick    (os_tick),
        .rx_in      (rx_in),
        .os_m       (os_m),
        .cfg_wlen   (cfg_wlen),
        .cfg_par_en (cfg_par_en),
        .cfg_even   (cfg_even),
        .cfg_stick  (cfg_stick),
        .push       (push),
        .push_data  (push_data),
        .pe_set     (pe_set),
        .fe_set     (fe_set)
    );

    uart_rx_break #(.CW(CHAR_W)) i_break (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_rst     (rx_rst),
        .os_tick    (os_tick),
        .rx_in      (rx_in),
        .char_ticks (char_ticks),
        .bi_set     (bi_set)
    );

    uart_rx_flags #(.N(3)) i_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  ({bi_set, fe_set, pe_set}),
        .clr_i  ({clr_bi, clr_fe, clr_pe}),
        .flag_o (flags)
    );

    // Flag outputs and combined line status.
    always_comb begin
        flag_pe     = flags[0];
        flag_fe     = flags[1];
        flag_bi     = flags[2];
        line_status = |flags;
    end

endmodule

// File: rtl/uart_rx_engine_chk.sv
// Property checker for the serial receive engine, bound to the top.
module uart_rx_engine_chk #(
    parameter int DIV_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_rst,
    input logic             rx_in,
    input logic             cfg_alt_os,
    input logic [DIV_W-1:0] cfg_ext_div,
    input logic             clr_pe,
    input logic             clr_fe,
    input logic             clr_bi,
    input logic             push,
    input logic             flag_pe,
    input logic             flag_fe,
    input logic             flag_bi,
    input logic             line_status
);
    AST_DIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_alt_os |-> (cfg_ext_div >= DIV_W'(8)));                      // R3
    AST_PE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_pe && !clr_pe) |=> flag_pe);                               // R9
    AST_FE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_fe && !clr_fe) |=> flag_fe);                               // R9
    AST_BI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_bi && !clr_bi) |=> flag_bi);                               // R9
    AST_BI_LOW_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_bi) |-> !$past(rx_in));                               // R8
    AST_STATUS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_status) |-> $past(clr_pe || clr_fe || clr_bi));       // R10
    AST_PUSH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !push);                                                 // R12
    AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rst |=> !push);                                               // R11
endmodule

bind uart_rx_engine uart_rx_engine_chk #(.DIV_W(DIV_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_rst      (rx_rst),
    .rx_in       (rx_in),
    .cfg_alt_os  (cfg_alt_os),
    .cfg_ext_div (cfg_ext_div),
    .clr_pe      (clr_pe),
    .clr_fe      (clr_fe),
    .clr_bi      (clr_bi),
    .push        (push),
    .flag_pe     (flag_pe),
    .flag_fe     (flag_fe),
    .flag_bi     (flag_bi),
    .line_status (line_status)
);

// File: tb/test_uart_rx_engine.sv
module test_uart_rx_engine;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 2;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       rx_rst = 0;
    logic       os_tick = 0;
    logic       rx_in = 1;
    logic [1:0] cfg_wlen = 2'b11;
    logic       cfg_par_en = 0, cfg_even = 0, cfg_stick = 0, cfg_alt_os = 0;
    logic [3:0] cfg_ext_div = 4'd0;
    logic       clr_pe = 0, clr_fe = 0, clr_bi = 0;
    logic       push;
    logic [7:0] push_data;
    logic       flag_pe, flag_fe, flag_bi, line_status;

    int checks = 0, errors = 0, npush = 0;
    int tdiv = 0;
    int cur_m = 16;
    bit mon_on = 0;
    logic [7:0] exp_q[$];

    uart_rx_engine i_uart_rx_engine (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Oversample tick, changed on the falling edge only.
    always @(negedge clk) begin
        tdiv    <= (tdiv == TICK_DIV-1) ? 0 : tdiv + 1;
        os_tick <= (tdiv == TICK_DIV-1);
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Reference queue compare on every clock.
    always @(negedge clk) begin
        if (mon_on) begin
            chk("R10 status", int'(line_status), int'(flag_pe | flag_fe | flag_bi));
            if (push) begin
                npush++;
                if (exp_q.size() == 0) begin
                    chk("R4 unexpected push", 1, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk("R2 data", int'(push_data), int'(e));
                end
            end
        end
    end

    task automatic hold(input int n);
        int k = 0;
        while (k < n) begin
            @(posedge clk);
            if (os_tick) k++;
        end
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input bit flip, input bit stopv);
        int nb;
        logic x;
        logic pb;
        nb = 5 + int'(cfg_wlen);
        x = 0;
        for (int i = 0; i < nb; i++) x ^= d[i];
        pb = cfg_stick ? ~cfg_even : (cfg_even ? x : ~x);
        exp_q.push_back(d & 8'((1 << nb) - 1));
        rx_in = 0; hold(cur_m);
        for (int i = 0; i < nb; i++) begin rx_in = d[i]; hold(cur_m); end
        if (cfg_par_en) begin rx_in = pb ^ flip; hold(cur_m); end
        rx_in = stopv; hold(cur_m);
        rx_in = 1; hold(2 * cur_m);
    endtask

    task automatic pulse_clr(input bit p, input bit f, input bit b);
        clr_pe = p; clr_fe = f; clr_bi = b;
        @(negedge clk);
        clr_pe = 0; clr_fe = 0; clr_bi = 0;
        @(negedge clk);
    endtask

    task automatic flags_are(input string req, input bit p, input bit f, input bit b);
        chk({req, " pe"}, int'(flag_pe), int'(p));
        chk({req, " fe"}, int'(flag_fe), int'(f));
        chk({req, " bi"}, int'(flag_bi), int'(b));
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int n0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 push", int'(push), 0);
        chk("R1 data", int'(push_data), 0);
        flags_are("R1", 0, 0, 0);
        chk("R1 status", int'(line_status), 0);
        rst_n = 1; mon_on = 1;
        repeat (4) @(negedge clk);

        // R2 / R12: 8-bit, no parity
        n0 = npush;
        send(8'hA5, 0, 1);
        chk("R12 one push", npush - n0, 1);
        flags_are("R2 clean", 0, 0, 0);
        cfg_wlen = 2'b00; send(8'h13, 0, 1);
        cfg_wlen = 2'b01; send(8'h2C, 0, 1);
        cfg_wlen = 2'b10; send(8'h5A, 0, 1);
        chk("R2 all popped", exp_q.size(), 0);

        // R3: alternate oversample factor M = 10
        cfg_wlen = 2'b11; cfg_ext_div = 4'd9; cfg_alt_os = 1; cur_m = 10;
        send(8'h3C, 0, 1);
        cfg_ext_div = 4'd15; cur_m = 16;
        send(8'hC3, 0, 1);
        cfg_alt_os = 0;
        chk("R3 pushes", exp_q.size(), 0);
        flags_are("R3 clean", 0, 0, 0);

        // R5: normal parity
        cfg_par_en = 1; cfg_even = 1; send(8'h07, 0, 1);
        cfg_even = 0; send(8'h07, 0, 1);
        flags_are("R5 good parity", 0, 0, 0);
        n0 = npush;
        cfg_even = 1; send(8'h81, 1, 1);
        chk("R7 bad char pushed", npush - n0, 1);
        flags_are("R5 bad parity", 1, 0, 0);
        chk("R10 status set", int'(line_status), 1);
        pulse_clr(1, 0, 0);
        flags_are("R9 cleared", 0, 0, 0);
        chk("R10 status clear", int'(line_status), 0);

        // R6: stick parity
        cfg_stick = 1; cfg_even = 0; send(8'h00, 0, 1);
        flags_are("R6 stick one ok", 0, 0, 0);
        send(8'hFF, 1, 1);
        flags_are("R6 stick one bad", 1, 0, 0);
        pulse_clr(1, 0, 0);
        cfg_even = 1; send(8'hFF, 0, 1);
        flags_are("R6 stick zero ok", 0, 0, 0);
        cfg_stick = 0; cfg_par_en = 0;

        // R7: framing error, character still pushed
        n0 = npush;
        send(8'h55, 0, 0);
        chk("R7 pushed", npush - n0, 1);
        flags_are("R7 framing", 0, 1, 0);
        pulse_clr(0, 0, 1);
        flags_are("R9 other clear ignored", 0, 1, 0);
        pulse_clr(0, 1, 0);
        flags_are("R9 fe cleared", 0, 0, 0);

        // R9: set and clear of the framing flag in the same cycle
        fork
            send(8'h66, 0, 0);
            begin
                @(negedge clk);
                while (!push) @(negedge clk);
                clr_fe = 1;
                @(negedge clk);
                clr_fe = 0;
            end
        join
        flags_are("R9 set wins", 0, 1, 0);
        pulse_clr(0, 1, 0);
        flags_are("R9 clear after clash", 0, 0, 0);

        // R4: start glitch shorter than half a bit
        n0 = npush;
        rx_in = 0; hold(3);
        rx_in = 1; hold(40);
        chk("R4 no push", npush - n0, 0);

        // R8: all-zero character is not a break
        send(8'h00, 0, 1);
        flags_are("R8 no break", 0, 0, 0);

        // R8: line low past a character time
        n0 = npush;
        exp_q.push_back(8'h00);
        rx_in = 0; hold(16 * 10 + 40);
        rx_in = 1; hold(32);
        chk("R8 single push", npush - n0, 1);
        flags_are("R8 break", 0, 1, 1);
        pulse_clr(0, 1, 1);
        flags_are("R8 cleared", 0, 0, 0);

        // R11: receive reset mid-character
        send(8'h12, 0, 0);
        n0 = npush;
        rx_in = 0; hold(16);
        rx_in = 1; hold(16);
        rx_in = 0; hold(8);
        rx_rst = 1; @(negedge clk);
        rx_rst = 0; rx_in = 1;
        hold(16 * 12);
        chk("R11 no push", npush - n0, 0);
        flags_are("R11 flags kept", 0, 1, 0);
        pulse_clr(0, 1, 0);
        send(8'h9E, 0, 1);
        chk("R11 recovers", npush - n0, 1);
        chk("R2 queue empty", exp_q.size(), 0);

        repeat (4) @(negedge clk);
        report();
    end
endmodule